// File: doc/BRIEF.md
# Shared-Adder Two-Sum Datapath

This block produces two independent small sums from four operand inputs while owning only one adder and one pair of operand registers. A free-running two-state sequencer inside the block alternates between a "pair 0" step and a "pair 1" step on every clock. In each step, a row of input multiplexers steers that step's operand pair into the operand registers. One cycle later, the adder result from those registers is written into the result register that belongs to the pair.

Results appear as `{carry, sum}` words. A one-cycle pulse marks the cycle in which the pair-1 result has just been written, so both result words then hold sums from one complete pass of the sequence. The step signal is not reachable from outside. A user holds the operands steady, or changes them only in the step that does not sample them, and reads both results when the pulse is seen. The operand width is a parameter, and the default of one bit gives a half adder.

Top module: `tmadd_top`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears `res0` and `res1` to zero, drives `both_vld` low and puts the sequencer in the pair-0 step.
- R2: Each result word equals the sum of its two sampled operands, with bit 0 the sum and bit W the carry. For W = 1 this means bit 0 = x XOR y and bit 1 = x AND y.
- R3: The sequencer changes step at every rising edge. The first edge after reset leaves the pair-0 step.
- R4: `p0_x` and `p0_y` are sampled only at edges that end a pair-0 step, and their sum reaches `res0` at the next edge. Changes to them at any other time have no effect on either result.
- R5: `p1_x` and `p1_y` are sampled only at edges that end a pair-1 step, and their sum reaches `res1` at the next edge. Changes to them at any other time have no effect on either result.
- R6: `res0` changes only at the edge that writes a pair-0 sum, and `res1` changes only at the edge that writes a pair-1 sum. The other word holds its value.
- R7: `both_vld` is high for exactly the one cycle after `res1` is written and is low otherwise. After reset is released it first rises after the third edge and then every second cycle.
- R8: A reset applied mid-sequence restarts the block from the R1 state. After release, the timing in R7 repeats from the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| p0_x | input | W | First operand of pair 0 |
| p0_y | input | W | Second operand of pair 0 |
| p1_x | input | W | First operand of pair 1 |
| p1_y | input | W | Second operand of pair 1 |
| res0 | output | W+1 | Pair-0 result, {carry, sum} |
| res1 | output | W+1 | Pair-1 result, {carry, sum} |
| both_vld | output | 1 | One-cycle pulse after both results are fresh |

## Verification
The checker assumes that operand inputs are settled before each rising edge and that reset is synchronous. It places no constraint on when operands change, because each property ties a register to the input values that were present at the edge the sequencer selects. The stimulus changes inputs only on falling edges. Every operand combination is held for whole sequences. The stimulus also deliberately flips the unsampled pair inside the step that ignores it, so the sampling rule is checked without ever leaving the assumed input timing.

// File: rtl/tmadd_pkg.sv
package tmadd_pkg;

  typedef enum logic {
    STEP_PAIR0 = 1'b0,
    STEP_PAIR1 = 1'b1
  } step_e;

  function automatic step_e step_after(input step_e cur);
    return (cur == STEP_PAIR0) ? STEP_PAIR1 : STEP_PAIR0;
  endfunction

endpackage

// File: rtl/tmadd_seq.sv
module tmadd_seq
  import tmadd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output step_e step
);

  always_ff @(posedge clk) begin
    if (rst) step <= STEP_PAIR0;
    else     step <= step_after(step);
  end

endmodule

// File: rtl/tmadd_operands.sv
module tmadd_operands
  import tmadd_pkg::*;
#(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  step_e        step,
  input  logic [W-1:0] p0_x,
  input  logic [W-1:0] p0_y,
  input  logic [W-1:0] p1_x,
  input  logic [W-1:0] p1_y,
  output logic [W-1:0] opr_x,
  output logic [W-1:0] opr_y,
  output logic         opr_tag,
  output logic         opr_vld
);

  logic [W-1:0] sel_x;
  logic [W-1:0] sel_y;

  // input multiplexers steered by the sequencer
  always_comb begin
    if (step == STEP_PAIR0) begin
      sel_x = p0_x;
      sel_y = p0_y;
    end else begin
      sel_x = p1_x;
      sel_y = p1_y;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opr_x   <= '0;
      opr_y   <= '0;
      opr_tag <= 1'b0;
      opr_vld <= 1'b0;
    end else begin
      opr_x   <= sel_x;
      opr_y   <= sel_y;
      opr_tag <= (step == STEP_PAIR1);
      opr_vld <= 1'b1;
    end
  end

endmodule

// File: rtl/tmadd_adder.sv
module tmadd_adder #(
  parameter int W = 1
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W:0]   total
);

  // ripple of half/full cells; for one bit: sum = x^y, carry = x&y
  function automatic logic [W:0] ripple_add(input logic [W-1:0] u,
                                            input logic [W-1:0] v);
    logic [W:0] r;
    logic       cy;
    cy = 1'b0;
    for (int i = 0; i < W; i++) begin
      r[i] = u[i] ^ v[i] ^ cy;
      cy   = (u[i] & v[i]) | (cy & (u[i] ^ v[i]));
    end
    r[W] = cy;
    return r;
  endfunction

  assign total = ripple_add(x, y);

endmodule

// File: rtl/tmadd_results.sv
module tmadd_results #(
  parameter int W = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr0,
  input  logic       wr1,
  input  logic [W:0] total,
  output logic [W:0] res0,
  output logic [W:0] res1,
  output logic       both_vld
);

  always_ff @(posedge clk) begin
    if (rst) begin
      res0     <= '0;
      res1     <= '0;
      both_vld <= 1'b0;
    end else begin
      if (wr0) res0 <= total;
      if (wr1) res1 <= total;
      both_vld <= wr1;
    end
  end

endmodule

// File: rtl/tmadd_top.sv
module tmadd_top
  import tmadd_pkg::*;
#(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] p0_x,
  input  logic [W-1:0] p0_y,
  input  logic [W-1:0] p1_x,
  input  logic [W-1:0] p1_y,
  output logic [W:0]   res0,
  output logic [W:0]   res1,
  output logic         both_vld
);

  step_e        step;
  logic [W-1:0] opr_x;
  logic [W-1:0] opr_y;
  logic         opr_tag;
  logic         opr_vld;
  logic [W:0]   total;
  logic         wr0;
  logic         wr1;

  tmadd_seq u_seq (
    .clk  (clk),
    .rst  (rst),
    .step (step)
  );

  tmadd_operands #(.W(W)) u_opr (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .p0_x    (p0_x),
    .p0_y    (p0_y),
    .p1_x    (p1_x),
    .p1_y    (p1_y),
    .opr_x   (opr_x),
    .opr_y   (opr_y),
    .opr_tag (opr_tag),
    .opr_vld (opr_vld)
  );

  tmadd_adder #(.W(W)) u_add (
    .x     (opr_x),
    .y     (opr_y),
    .total (total)
  );

  // named write events, visible to the checker
  assign wr0 = opr_vld & ~opr_tag;
  assign wr1 = opr_vld &  opr_tag;

  tmadd_results #(.W(W)) u_res (
    .clk      (clk),
    .rst      (rst),
    .wr0      (wr0),
    .wr1      (wr1),
    .total    (total),
    .res0     (res0),
    .res1     (res1),
    .both_vld (both_vld)
  );

endmodule

// File: rtl/tmadd_chk.sv
module tmadd_chk #(
  parameter int W = 1
) (
  input logic         clk,
  input logic         rst,
  input logic         step_bit,
  input logic [W-1:0] p0_x,
  input logic [W-1:0] p0_y,
  input logic [W-1:0] p1_x,
  input logic [W-1:0] p1_y,
  input logic [W-1:0] opr_x,
  input logic [W-1:0] opr_y,
  input logic         wr0,
  input logic         wr1,
  input logic [W:0]   res0,
  input logic [W:0]   res1,
  input logic         both_vld
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (res0 == '0 && res1 == '0 && !both_vld && !step_bit));

  // R3
  step_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (step_bit != $past(step_bit)));

  // R4
  pair0_sample_chk: assert property (@(posedge clk) disable iff (rst)
    !step_bit |=> (opr_x == $past(p0_x) && opr_y == $past(p0_y)));

  // R5
  pair1_sample_chk: assert property (@(posedge clk) disable iff (rst)
    step_bit |=> (opr_x == $past(p1_x) && opr_y == $past(p1_y)));

  // R2
  res0_value_chk: assert property (@(posedge clk) disable iff (rst)
    wr0 |=> (res0 == ((W+1)'($past(opr_x)) + (W+1)'($past(opr_y)))));

  // R2
  res1_value_chk: assert property (@(posedge clk) disable iff (rst)
    wr1 |=> (res1 == ((W+1)'($past(opr_x)) + (W+1)'($past(opr_y)))));

  // R6
  res0_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr0 |=> $stable(res0));

  // R6
  res1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr1 |=> $stable(res1));

  // R6
  one_writer_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr0, wr1}));

  // R7
  done_follows_chk: assert property (@(posedge clk) disable iff (rst)
    wr1 |=> both_vld);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    both_vld |=> !both_vld);

endmodule

bind tmadd_top tmadd_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .step_bit (step),
  .p0_x     (p0_x),
  .p0_y     (p0_y),
  .p1_x     (p1_x),
  .p1_y     (p1_y),
  .opr_x    (opr_x),
  .opr_y    (opr_y),
  .wr0      (wr0),
  .wr1      (wr1),
  .res0     (res0),
  .res1     (res1),
  .both_vld (both_vld)
);

// File: tb/sim_tmadd_top.sv
`timescale 1ns/1ps
module sim_tmadd_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       p0_x = 1'b0, p0_y = 1'b0, p1_x = 1'b0, p1_y = 1'b0;
  logic [1:0] res0, res1;
  logic       both_vld;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #10 clk = ~clk;  // 50 MHz

  tmadd_top #(.W(1)) u0 (
    .clk(clk), .rst(rst),
    .p0_x(p0_x), .p0_y(p0_y), .p1_x(p1_x), .p1_y(p1_y),
    .res0(res0), .res1(res1), .both_vld(both_vld)
  );

  // behavioural reference: a queue of pending writes, tagged by target
  int exp0 = 0, exp1 = 0;
  bit exp_done = 0;
  int edges = 0;
  int pend[$];

  always @(posedge clk) begin
    if (rst) begin
      exp0 = 0; exp1 = 0; exp_done = 0; edges = 0;
      pend.delete();
    end else begin
      edges++;
      exp_done = 0;
      if (pend.size() > 0) begin
        int v;
        v = pend.pop_front();
        if ((v >> 2) == 1) exp0 = v & 3;
        else begin exp1 = v & 3; exp_done = 1; end
      end
      if (edges % 2 == 1) pend.push_back(4 + int'(p0_x) + int'(p0_y));
      else                pend.push_back(8 + int'(p1_x) + int'(p1_y));
    end
  end

  // every-cycle comparison (R2 R4 R5 R6 R7)
  always @(negedge clk) begin
    if (!ended) begin
      checks++;
      if (int'(res0) != exp0 || int'(res1) != exp1 || both_vld != exp_done) begin
        errors++;
        $display("FAIL R2/R4/R5/R6/R7 per-cycle t=%0t: got res0=%0d res1=%0d done=%0b, expected %0d %0d %0b",
                 $time, res0, res1, both_vld, exp0, exp1, exp_done);
      end
    end
  end

  task automatic check(input string req, input int got, input int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  task automatic drive(input logic a0, input logic b0, input logic a1, input logic b1);
    p0_x = a0; p0_y = b0; p1_x = a1; p1_y = b1;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 res0", int'(res0), 0);
    check("R1 res1", int'(res1), 0);
    check("R1 done", int'(both_vld), 0);

    // R3 R7: first pulse after third edge
    drive(1, 1, 1, 0);
    rst = 1'b0;
    @(negedge clk); check("R7 no pulse edge1", int'(both_vld), 0);
    @(negedge clk); check("R3 pair0 written edge2", int'(res0), 2);
                    check("R7 no pulse edge2", int'(both_vld), 0);
    @(negedge clk); check("R3 pair1 written edge3", int'(res1), 1);
                    check("R7 pulse edge3", int'(both_vld), 1);
    @(negedge clk); check("R7 pulse single", int'(both_vld), 0);
    @(negedge clk); check("R7 pulse period", int'(both_vld), 1);

    // R2 all 16 operand combinations
    for (int i = 0; i < 16; i++) begin
      drive(i[0], i[1], i[2], i[3]);
      repeat (4) @(negedge clk);
      if (!both_vld) @(negedge clk);
      check("R2 res0 sum", int'(res0), int'(i[0]) + int'(i[1]));
      check("R2 res1 sum", int'(res1), int'(i[2]) + int'(i[3]));
    end

    // R4 R5: flip the unsampled pair in the step that ignores it
    while (!both_vld) @(negedge clk);
    drive(0, 0, 1, 1);
    @(negedge clk); drive(1, 1, 0, 0);
    @(negedge clk); drive(0, 0, 1, 1);
    @(negedge clk);
    check("R4 res0 ignores pair0 change", int'(res0), 2);
    drive(1, 1, 0, 0);
    @(negedge clk);
    check("R5 res1 ignores pair1 change", int'(res1), 2);
    check("R5 pulse", int'(both_vld), 1);

    // R8 reset mid-sequence
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 res0 cleared", int'(res0), 0);
    check("R8 res1 cleared", int'(res1), 0);
    check("R8 done low", int'(both_vld), 0);
    drive(0, 1, 1, 1);
    rst = 1'b0;
    @(negedge clk); check("R8 no pulse edge1", int'(both_vld), 0);
    @(negedge clk); check("R8 res0 after restart", int'(res0), 1);
    @(negedge clk); check("R8 pulse edge3", int'(both_vld), 1);
                    check("R8 res1 after restart", int'(res1), 2);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule